// File: doc/BRIEF.md
# GPIO Port with Change Interrupt

An eight-pin bidirectional port for a small microcontroller. Software reaches it through a simple register bus. It can write an output latch, select the direction of each pin, and mark pins as analog. Pins selected as analog always read back as zero. The four upper pins add two things: a weak pull-up request, and a change detector that can be enabled pin by pin. A pull-up request is suppressed while its pin drives, and also while a global pull-up disable bit is set.

Every pin input passes through a two-flop synchronizer. The change detector compares each enabled upper pin against a snapshot taken at the last port access; a read or a write of the port both count. Any difference raises a sticky change flag, which also drives the wake output. A clear request succeeds only once the mismatch has gone. While the mismatch lasts, the flag is raised again on every cycle. During a port access cycle the comparison is suppressed and the snapshot takes the freshly sampled value. A pin edge that lands in that cycle therefore produces no flag.

Reset comes as a 2-bit kind. A power-on reset clears everything. A pin reset or a brown-out reset leaves the snapshot and the enables intact, so a mismatch that is still present raises the flag again after reset. The flag logic is a two-state machine. State CHG_IDLE goes to CHG_RAISED on a mismatch (the transition called "raise"). CHG_RAISED returns to CHG_IDLE on a clear request made with no mismatch present (the transition called "clear"). Any reset kind forces CHG_IDLE (the transition called "reset").

Top module: `pin_port_ctl`

## Requirements
- R1: During and after a power-on reset (rst_kind 1), the registers hold these values. Direction (address 1) reads 8'hFF, where a 1 bit means input. Analog select (address 2) reads 8'hFF. Pull-up enable (address 3, bits 7:4) reads 0. Change enable (address 4, bits 7:4) reads 0. Option (address 5) reads 8'h80, where bit 7 is the global pull-up disable. Flag (address 6, bit 0) reads 0, and pad_oe is 0. The snapshot is cleared to 0.
- R2: A read of the port (address 0) returns the synchronized pin values, with every bit whose analog-select bit is 1 forced to 0. pad_analog mirrors the analog-select register.
- R3: A write to the direction register sets pad_oe to its inverse from the next cycle, regardless of analog selection. A write to the port sets pad_out to the written value.
- R4: pad_pu[i] requests a pull-up on pin 4+i. It is 1 only when all three hold: enable bit 4+i is set, direction bit 4+i is 1 (input), and option bit 7 is 0.
- R5: While an enabled upper pin differs from its snapshot, chg_flag and wake become 1 one cycle after the synchronized value changes. A pin whose change-enable bit is 0 never sets the flag.
- R6: Writing the flag register with bit 0 = 0 clears the flag only if no mismatch is present. Otherwise the flag stays set.
- R7: Any read or write of the port reloads the snapshot from the synchronized pins, which ends the mismatch.
- R8: A pin reset (rst_kind 2) or a brown-out reset (rst_kind 3) returns direction and analog select to 8'hFF and clears the flag. The snapshot, the change enables and the pull-up enables are kept, so a persisting mismatch raises the flag again after reset.
- R9: In a cycle where the port is accessed, the flag is not raised. A pin change that first reaches the synchronizer output in that cycle is loaded into the snapshot and produces no flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_kind | input | 2 | Synchronous reset kind: 0 none, 1 power-on, 2 pin, 3 brown-out |
| bus_sel | input | 1 | Bus access strobe for this cycle |
| bus_wr | input | 1 | 1 for write, 0 for read |
| bus_addr | input | 3 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for the addressed register (combinational) |
| pin_in | input | 8 | Asynchronous pin levels |
| pad_out | output | 8 | Output latch toward the pads |
| pad_oe | output | 8 | Per-pin output drive enable |
| pad_pu | output | 4 | Weak pull-up request for pins 7:4 |
| pad_analog | output | 8 | Per-pin analog selection |
| chg_flag | output | 1 | Sticky port-change flag |
| wake | output | 1 | Wake request from the change flag |

## Verification
If the snapshot is wrong, the fault shows on chg_flag and wake. The flag either never rises, or it cannot be cleared after a port read. Either way the error appears within three cycles of the pin edge or the clear request. If the FSM holds a wrong state, clear requests either take effect while a mismatch is present or fail when none is present, and the flag register shows this on the next read. Errors in the reset handling appear at the first register readback after reset. They can show as direction or analog values that were not restored. They can also show as enables or a snapshot that were lost, in which case a persisting mismatch no longer re-raises the flag.

// File: rtl/pin_port_pkg.sv
package pin_port_pkg;

    localparam int ADDR_W = 3;

    typedef enum logic [1:0] {
        RK_NONE  = 2'd0,
        RK_POWER = 2'd1,
        RK_PIN   = 2'd2,
        RK_BROWN = 2'd3
    } rst_kind_e;

    typedef enum logic [ADDR_W-1:0] {
        RA_PORT  = 3'd0,
        RA_DIR   = 3'd1,
        RA_ANSEL = 3'd2,
        RA_PUEN  = 3'd3,
        RA_IOC   = 3'd4,
        RA_OPT   = 3'd5,
        RA_FLAG  = 3'd6
    } reg_addr_e;

    typedef enum logic {
        CHG_IDLE   = 1'b0,
        CHG_RAISED = 1'b1
    } chg_state_e;

endpackage

// File: rtl/pin_sync.sv
module pin_sync #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         clr,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stage1;
    logic [W-1:0] stage2;

    always_ff @(posedge clk) begin
        if (clr) begin
            stage1 <= '0;
            stage2 <= '0;
        end else begin
            stage1 <= d;
            stage2 <= stage1;
        end
    end

    assign q = stage2;
endmodule

// File: rtl/pin_chg_detect.sv
module pin_chg_detect
    import pin_port_pkg::*;
#(
    parameter int HI = 4
) (
    input  logic          clk,
    input  logic          rst_any,
    input  logic          rst_por,
    input  logic [HI-1:0] pins_q,
    input  logic [HI-1:0] ioc_en,
    input  logic          port_access,
    input  logic          flag_clr,
    output logic          chg_flag
);
    chg_state_e    state_q;
    chg_state_e    state_d;
    logic [HI-1:0] snap_q;
    logic          mismatch;

    // Snapshot survives every reset kind except power-on
    always_ff @(posedge clk) begin
        if (rst_por)
            snap_q <= '0;
        else if (port_access)
            snap_q <= pins_q;
    end

    // Comparison is masked while an access reloads the snapshot
    assign mismatch = (|(ioc_en & (pins_q ^ snap_q))) && !port_access;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            CHG_IDLE:   if (mismatch) state_d = CHG_RAISED;
            CHG_RAISED: if (flag_clr && !mismatch) state_d = CHG_IDLE;
            default:    state_d = CHG_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst_any)
            state_q <= CHG_IDLE;
        else
            state_q <= state_d;
    end

    always_comb begin
        chg_flag = (state_q == CHG_RAISED);
    end
endmodule

// File: rtl/pin_port_ctl.sv
module pin_port_ctl
    import pin_port_pkg::*;
#(
    parameter int WIDTH   = 8,
    parameter int HI_PINS = 4
) (
    input  logic               clk,
    input  logic [1:0]         rst_kind,
    input  logic               bus_sel,
    input  logic               bus_wr,
    input  logic [ADDR_W-1:0]  bus_addr,
    input  logic [WIDTH-1:0]   bus_wdata,
    output logic [WIDTH-1:0]   bus_rdata,
    input  logic [WIDTH-1:0]   pin_in,
    output logic [WIDTH-1:0]   pad_out,
    output logic [WIDTH-1:0]   pad_oe,
    output logic [HI_PINS-1:0] pad_pu,
    output logic [WIDTH-1:0]   pad_analog,
    output logic               chg_flag,
    output logic               wake
);
    localparam int LO = WIDTH - HI_PINS;

    logic               rst_any;
    logic               rst_por;
    reg_addr_e          addr;
    logic               wr_hit;
    logic               port_access;
    logic               flag_clr;
    logic [WIDTH-1:0]   pins_s;
    logic [WIDTH-1:0]   out_q;
    logic [WIDTH-1:0]   dir_q;
    logic [WIDTH-1:0]   ansel_q;
    logic [HI_PINS-1:0] puen_q;
    logic [HI_PINS-1:0] ioc_q;
    logic               pud_q;

    assign rst_any     = (rst_kind != RK_NONE);
    assign rst_por     = (rst_kind == RK_POWER);
    assign addr        = reg_addr_e'(bus_addr);
    assign wr_hit      = bus_sel && bus_wr && !rst_any;
    assign port_access = bus_sel && !rst_any && (addr == RA_PORT);
    assign flag_clr    = wr_hit && (addr == RA_FLAG) && !bus_wdata[0];

    pin_sync #(.W(WIDTH)) u_sync (
        .clk (clk),
        .clr (rst_por),
        .d   (pin_in),
        .q   (pins_s)
    );

    always_ff @(posedge clk) begin
        if (rst_any) begin
            dir_q   <= '1;
            ansel_q <= '1;
            if (rst_por) begin
                out_q  <= '0;
                puen_q <= '0;
                ioc_q  <= '0;
                pud_q  <= 1'b1;
            end
        end else if (wr_hit) begin
            unique case (addr)
                RA_PORT:  out_q   <= bus_wdata;
                RA_DIR:   dir_q   <= bus_wdata;
                RA_ANSEL: ansel_q <= bus_wdata;
                RA_PUEN:  puen_q  <= bus_wdata[WIDTH-1:LO];
                RA_IOC:   ioc_q   <= bus_wdata[WIDTH-1:LO];
                RA_OPT:   pud_q   <= bus_wdata[WIDTH-1];
                default:  ;
            endcase
        end
    end

    pin_chg_detect #(.HI(HI_PINS)) u_chg (
        .clk         (clk),
        .rst_any     (rst_any),
        .rst_por     (rst_por),
        .pins_q      (pins_s[WIDTH-1:LO]),
        .ioc_en      (ioc_q),
        .port_access (port_access),
        .flag_clr    (flag_clr),
        .chg_flag    (chg_flag)
    );

    always_comb begin
        unique case (addr)
            RA_PORT:  bus_rdata = pins_s & ~ansel_q;
            RA_DIR:   bus_rdata = dir_q;
            RA_ANSEL: bus_rdata = ansel_q;
            RA_PUEN:  bus_rdata = {puen_q, {LO{1'b0}}};
            RA_IOC:   bus_rdata = {ioc_q, {LO{1'b0}}};
            RA_OPT:   bus_rdata = {pud_q, {(WIDTH-1){1'b0}}};
            RA_FLAG:  bus_rdata = {{(WIDTH-1){1'b0}}, chg_flag};
            default:  bus_rdata = '0;
        endcase
    end

    assign pad_out    = out_q;
    assign pad_oe     = ~dir_q;
    assign pad_analog = ansel_q;
    assign pad_pu     = puen_q & dir_q[WIDTH-1:LO] & {HI_PINS{~pud_q}};
    assign wake       = chg_flag;
endmodule

// File: rtl/pin_port_chk.sv
module pin_port_chk
    import pin_port_pkg::*;
#(
    parameter int WIDTH   = 8,
    parameter int HI_PINS = 4
) (
    input logic               clk,
    input logic [1:0]         rst_kind,
    input logic               bus_sel,
    input logic               bus_wr,
    input logic [ADDR_W-1:0]  bus_addr,
    input logic [WIDTH-1:0]   bus_wdata,
    input logic [WIDTH-1:0]   bus_rdata,
    input logic [WIDTH-1:0]   pad_oe,
    input logic [HI_PINS-1:0] pad_pu,
    input logic [WIDTH-1:0]   pad_analog,
    input logic               chg_flag,
    input logic [HI_PINS-1:0] ioc_en
);
    localparam int LO = WIDTH - HI_PINS;

    logic rst_on;
    assign rst_on = (rst_kind != 2'd0);

    a_r1_after_reset: assert property (@(posedge clk) disable iff (rst_on)
        $past(rst_on) |-> (pad_oe == '0) && !chg_flag);

    a_r2_analog_reads_zero: assert property (@(posedge clk) disable iff (rst_on)
        (bus_sel && !bus_wr && bus_addr == 3'd0) |-> ((bus_rdata & pad_analog) == '0));

    a_r3_oe_from_dir_write: assert property (@(posedge clk) disable iff (rst_on)
        (bus_sel && bus_wr && bus_addr == 3'd1) |=> (pad_oe == ~$past(bus_wdata)));

    a_r4_no_pullup_when_driving: assert property (@(posedge clk) disable iff (rst_on)
        ((pad_pu & pad_oe[WIDTH-1:LO]) == '0));

    a_r5_flag_needs_enable: assert property (@(posedge clk) disable iff (rst_on)
        $rose(chg_flag) |-> ($past(ioc_en) != '0));

    a_r6_flag_sticky: assert property (@(posedge clk) disable iff (rst_on)
        (chg_flag && !(bus_sel && bus_wr && bus_addr == 3'd6 && !bus_wdata[0])) |=> chg_flag);

    a_r9_no_raise_on_access: assert property (@(posedge clk) disable iff (rst_on)
        (bus_sel && bus_addr == 3'd0 && !chg_flag) |=> !chg_flag);
endmodule

bind pin_port_ctl pin_port_chk #(.WIDTH(WIDTH), .HI_PINS(HI_PINS)) u_chk (
    .clk        (clk),
    .rst_kind   (rst_kind),
    .bus_sel    (bus_sel),
    .bus_wr     (bus_wr),
    .bus_addr   (bus_addr),
    .bus_wdata  (bus_wdata),
    .bus_rdata  (bus_rdata),
    .pad_oe     (pad_oe),
    .pad_pu     (pad_pu),
    .pad_analog (pad_analog),
    .chg_flag   (chg_flag),
    .ioc_en     (ioc_q)
);

// File: tb/test_pin_port_ctl.sv
module test_pin_port_ctl;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic [1:0] rst_kind = 2'd0;
    logic       bus_sel = 1'b0;
    logic       bus_wr = 1'b0;
    logic [2:0] bus_addr = 3'd0;
    logic [7:0] bus_wdata = 8'h00;
    logic [7:0] bus_rdata;
    logic [7:0] pin_in = 8'h00;
    logic [7:0] pad_out;
    logic [7:0] pad_oe;
    logic [3:0] pad_pu;
    logic [7:0] pad_analog;
    logic       chg_flag;
    logic       wake;

    int n_chk = 0;
    int n_fail = 0;
    logic [7:0] rd;

    always #(CLK_PERIOD/2) clk = ~clk;

    pin_port_ctl i_pin_port_ctl (
        .clk(clk), .rst_kind(rst_kind), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .pin_in(pin_in), .pad_out(pad_out), .pad_oe(pad_oe), .pad_pu(pad_pu),
        .pad_analog(pad_analog), .chg_flag(chg_flag), .wake(wake)
    );

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic do_reset(input logic [1:0] k);
        @(negedge clk);
        rst_kind = k;
        repeat (2) @(negedge clk);
        rst_kind = 2'd0;
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic rdreg(input logic [2:0] a, output logic [7:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
        #1 d = bus_rdata;
        @(negedge clk);
        bus_sel = 1'b0;
    endtask

    task automatic t_reset;
        do_reset(2'd1);
        rdreg(3'd1, rd); check("R1 dir", rd, 8'hFF);
        rdreg(3'd2, rd); check("R1 ansel", rd, 8'hFF);
        rdreg(3'd3, rd); check("R1 puen", rd, 8'h00);
        rdreg(3'd4, rd); check("R1 ioc", rd, 8'h00);
        rdreg(3'd5, rd); check("R1 opt", rd, 8'h80);
        rdreg(3'd6, rd); check("R1 flag", rd, 8'h00);
        check("R1 pad_oe", pad_oe, 8'h00);
    endtask

    task automatic t_read_analog;
        pin_in = 8'hA5;
        idle(3);
        wr(3'd2, 8'h0F);
        rdreg(3'd0, rd); check("R2 analog low bits read 0", rd, 8'hA0);
        check("R2 pad_analog", pad_analog, 8'h0F);
        wr(3'd2, 8'h00);
        rdreg(3'd0, rd); check("R2 all digital", rd, 8'hA5);
    endtask

    task automatic t_output;
        wr(3'd1, 8'h0F);
        check("R3 oe from dir", pad_oe, 8'hF0);
        wr(3'd0, 8'h3C);
        check("R3 pad_out", pad_out, 8'h3C);
        wr(3'd2, 8'hFF);
        check("R3 oe ignores analog", pad_oe, 8'hF0);
        wr(3'd2, 8'h00);
    endtask

    task automatic t_pullup;
        wr(3'd1, 8'hFF);
        wr(3'd3, 8'hF0);
        check("R4 global disable wins", {4'h0, pad_pu}, 8'h00);
        wr(3'd5, 8'h00);
        check("R4 all inputs", {4'h0, pad_pu}, 8'h0F);
        wr(3'd1, 8'h3F);
        check("R4 outputs drop pullup", {4'h0, pad_pu}, 8'h03);
        wr(3'd5, 8'h80);
        check("R4 disable again", {4'h0, pad_pu}, 8'h00);
        wr(3'd1, 8'hFF);
    endtask

    task automatic t_change;
        pin_in = 8'h00;
        idle(3);
        rdreg(3'd0, rd);
        wr(3'd6, 8'h00);
        wr(3'd4, 8'h00);
        pin_in = 8'h80;
        idle(4);
        check("R5 disabled pin no flag", {7'h0, chg_flag}, 8'h00);
        rdreg(3'd0, rd);
        wr(3'd4, 8'h10);
        @(negedge clk) pin_in = 8'h90;
        idle(3);
        check("R5 flag set", {7'h0, chg_flag}, 8'h01);
        check("R5 wake", {7'h0, wake}, 8'h01);
        wr(3'd6, 8'h00);
        idle(2);
        check("R6 clear refused in mismatch", {7'h0, chg_flag}, 8'h01);
        rdreg(3'd0, rd);
        wr(3'd6, 8'h00);
        check("R6 clear after read", {7'h0, chg_flag}, 8'h00);
    endtask

    task automatic t_write_reload;
        @(negedge clk) pin_in = 8'h80;
        idle(4);
        check("R7 flag before write", {7'h0, chg_flag}, 8'h01);
        wr(3'd0, 8'h55);
        wr(3'd6, 8'h00);
        idle(2);
        check("R7 write reloads snapshot", {7'h0, chg_flag}, 8'h00);
    endtask

    task automatic t_soft_reset(input logic [1:0] k, input string tag);
        wr(3'd1, 8'h00);
        @(negedge clk) pin_in = pin_in ^ 8'h10;
        idle(4);
        do_reset(k);
        idle(2);
        check({"R8 flag again ", tag}, {7'h0, chg_flag}, 8'h01);
        check({"R8 dir reset ", tag}, pad_oe, 8'h00);
        check({"R8 ansel reset ", tag}, pad_analog, 8'hFF);
        rdreg(3'd4, rd); check({"R8 ioc kept ", tag}, rd, 8'h10);
        wr(3'd2, 8'h00);
        rdreg(3'd0, rd);
        wr(3'd6, 8'h00);
        check({"R8 clears ", tag}, {7'h0, chg_flag}, 8'h00);
    endtask

    task automatic t_coincide;
        rdreg(3'd0, rd);
        wr(3'd6, 8'h00);
        @(negedge clk) pin_in = pin_in ^ 8'h10;
        @(negedge clk);
        rdreg(3'd0, rd);
        check("R9 read sees new level", rd & 8'h10, pin_in & 8'h10);
        idle(4);
        check("R9 coinciding change missed", {7'h0, chg_flag}, 8'h00);
    endtask

    task automatic t_por_clears;
        @(negedge clk) pin_in = pin_in ^ 8'h10;
        do_reset(2'd1);
        idle(4);
        check("R1 no flag after power-on", {7'h0, chg_flag}, 8'h00);
        rdreg(3'd4, rd); check("R1 ioc cleared", rd, 8'h00);
    endtask

    initial begin : watchdog
        #(CLK_PERIOD * 100000);
        n_chk++; n_fail++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin : main
        t_reset();
        t_read_analog();
        t_output();
        t_pullup();
        t_change();
        t_write_reload();
        t_soft_reset(2'd2, "pin");
        t_soft_reset(2'd3, "brown");
        t_coincide();
        t_por_clears();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule